// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Set/Clear Access

This block is a port of up to 32 general-purpose pins. It sits behind a small memory-mapped register interface with a 32-bit data path. It holds one output latch bit and one direction bit per pin. Each pin's pad output-enable follows its direction bit, and its pad output value follows its output latch bit. Pad inputs pass through a two-stage synchronizer before software can read them.

Software can write the output latch and the direction register whole. It can also change single bits through separate set and clear addresses. A write to one of these addresses changes only the bits whose write-data bit is 1, so two agents sharing the port never need a read-modify-write sequence. Reading the pin-state address gives a merged view: the output latch for output pins and the synchronized pad level for input pins. The usual way to turn a pin into an output is to load its value first and then set its direction bit.

Top module: `gpio_port`

## Requirements
- R1: After reset the output latch and the direction register are all zero: every pad_oe and pad_out bit is 0, and reads of offsets 0x00 and 0x08 return 0.
- R2: A write to offset 0x00 replaces the whole output latch. pad_out shows the new value from the cycle after the write, and a read of 0x00 returns it.
- R3: A write to offset 0x08 replaces the whole direction register. A direction bit of 1 makes the pin an output (pad_oe bit = 1) and a bit of 0 makes it an input. A read of 0x08 returns the register.
- R4: A write to offset 0x40 sets each output latch bit whose write-data bit is 1. All other bits are left unchanged.
- R5: A write to offset 0x44 clears each output latch bit whose write-data bit is 1. All other bits are left unchanged.
- R6: A write to offset 0x48 sets direction bits and a write to offset 0x4C clears direction bits. Both use the same write-one rule, and bits written as 0 keep their value.
- R7: A read of offset 0x04 returns, for each pin, the output latch bit when its direction bit is 1. When the direction bit is 0 it returns the pad level after two synchronizer flops. A pad change made just before a clock edge is not seen by a read sampled on the next edge.
- R8: Writes to offset 0x04 and to unmapped offsets change neither the output latch nor the direction register.
- R9: Reads of the four set/clear offsets (0x40, 0x44, 0x48, 0x4C) and of any unmapped offset return 0.
- R10: rd_data holds the result of a read in the cycle after rd_en is sampled high. In any cycle after rd_en was sampled low, rd_data is 0.
- R11: When a pin's output value is loaded while the pin is an input, and its direction bit is set afterwards, pad_out already holds the new value in the cycle pad_oe rises. pad_out does not change in any cycle in which pad_oe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |

## Verification
The assertions assume that wr_en and rd_en are never both high in the same cycle, and that at most one register address is decoded per write. The decoder is one-hot, so no single write can both set and clear a bit. The assertions also assume wr_en and rd_en are low throughout reset. The stimulus drives every strobe for exactly one cycle, separates reads from writes, holds strobes low during reset, and changes pad_in only on the falling clock edge, away from the sampling edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_OUT     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PIN     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_OUT_SET = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_DIR_SET = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR = 8'h4C;

    typedef enum logic [2:0] {
        SEL_OUT,
        SEL_PIN,
        SEL_DIR,
        SEL_OUT_SET,
        SEL_OUT_CLR,
        SEL_DIR_SET,
        SEL_DIR_CLR,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic load;
        logic set;
        logic clr;
    } bank_op_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        unique case (a)
            OFS_OUT:     return SEL_OUT;
            OFS_PIN:     return SEL_PIN;
            OFS_DIR:     return SEL_DIR;
            OFS_OUT_SET: return SEL_OUT_SET;
            OFS_OUT_CLR: return SEL_OUT_CLR;
            OFS_DIR_SET: return SEL_DIR_SET;
            OFS_DIR_CLR: return SEL_DIR_CLR;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic bank_op_t bank_op(input logic we, input reg_sel_e sel,
                                         input reg_sel_e s_load,
                                         input reg_sel_e s_set,
                                         input reg_sel_e s_clr);
        bank_op_t op;
        op.load = we && (sel == s_load);
        op.set  = we && (sel == s_set);
        op.clr  = we && (sel == s_clr);
        return op;
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_op_t         op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_next;

    always_comb begin
        q_next = q;
        if (op.load)     q_next = wdata;
        else if (op.set) q_next = q | wdata;
        else if (op.clr) q_next = q & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    AST_BANK_RESET_ZERO: assert property (@(posedge clk)
        $fell(rst) |-> (q == '0));                                          // R1

    AST_BANK_SET_MASK: assert property (@(posedge clk) disable iff (rst)
        $past(op.set) |-> (((q & $past(wdata)) == $past(wdata)) &&
                           ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))); // R4

    AST_BANK_CLR_MASK: assert property (@(posedge clk) disable iff (rst)
        $past(op.clr) |-> (((q & $past(wdata)) == '0) &&
                           ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))))); // R5

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(op.load || op.set || op.clr) |-> $stable(q));               // R8

    AST_BANK_ONE_OP: assert property (@(posedge clk) disable iff (rst)
        $countones({op.load, op.set, op.clr}) <= 1);                        // R6
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [NPINS-1:0]  out_q,
    input  logic [NPINS-1:0]  dir_q,
    input  logic [NPINS-1:0]  pad_sync,
    output logic [DATA_W-1:0] rd_data
);
    logic [NPINS-1:0]  pin_view;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        pin_view = (dir_q & out_q) | (~dir_q & pad_sync);
        rd_next  = '0;
        if (rd_en) begin
            case (sel)
                SEL_OUT: rd_next = DATA_W'(out_q);
                SEL_PIN: rd_next = DATA_W'(pin_view);
                SEL_DIR: rd_next = DATA_W'(dir_q);
                default: rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rd_data == '0));                                 // R10

    AST_RD_ALIAS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && (sel != SEL_OUT) && (sel != SEL_PIN) && (sel != SEL_DIR))
        |-> (rd_data == '0));                                               // R9

    AST_RD_OUT_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && (sel == SEL_OUT)) |-> (rd_data == DATA_W'($past(out_q)))); // R2
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    reg_sel_e         sel;
    bank_op_t         out_op;
    bank_op_t         dir_op;
    logic [NPINS-1:0] wbits;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] pad_sync;

    assign sel    = decode_addr(addr);
    assign wbits  = wr_data[NPINS-1:0];
    assign out_op = bank_op(wr_en, sel, SEL_OUT, SEL_OUT_SET, SEL_OUT_CLR);
    assign dir_op = bank_op(wr_en, sel, SEL_DIR, SEL_DIR_SET, SEL_DIR_CLR);

    gpio_port_bank #(.WIDTH(NPINS)) u_out_bank (
        .clk(clk), .rst(rst), .op(out_op), .wdata(wbits), .q(out_q)
    );

    gpio_port_bank #(.WIDTH(NPINS)) u_dir_bank (
        .clk(clk), .rst(rst), .op(dir_op), .wdata(wbits), .q(dir_q)
    );

    gpio_port_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync)
    );

    gpio_port_rdmux #(.NPINS(NPINS), .DATA_W(DATA_W)) u_rdmux (
        .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel),
        .out_q(out_q), .dir_q(dir_q), .pad_sync(pad_sync), .rd_data(rd_data)
    );

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    AST_OE_RISE_NO_GLITCH: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ $past(pad_out)) & (pad_oe & ~$past(pad_oe))) == '0)); // R11

    AST_DIR_IGNORES_OUT_WRITES: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && (sel == SEL_OUT_SET || sel == SEL_OUT_CLR || sel == SEL_OUT))
        |-> $stable(pad_oe));                                               // R3

    AST_PIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && (sel == SEL_PIN || sel == SEL_NONE))
        |-> ($stable(pad_out) && $stable(pad_oe)));                         // R8
endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_out = '0;
    logic [31:0] m_dir = '0;
    logic [31:0] m_pad = '0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pend = 1'b0;

    always #5 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pin_view();
        return (m_dir & m_out) | (~m_dir & m_pad);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    always @(posedge clk) rd_pend <= rd_en;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 unexpected read result actual=%08h expected=none", rd_data);
            end else begin
                string t;
                logic [31:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    initial begin
        #2_000_000;
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 pad_out after reset", pad_out, 32'h0);
        rd(8'h00, 32'h0, "R1 output reg after reset");
        rd(8'h08, 32'h0, "R1 direction reg after reset");

        wr(8'h00, 32'h1234_5678); m_out = 32'h1234_5678;
        check("R2 pad_out after direct write", pad_out, m_out);
        rd(8'h00, m_out, "R2 output readback");

        wr(8'h40, 32'h0000_00FF); m_out = m_out | 32'h0000_00FF;
        check("R4 pad_out after set alias", pad_out, m_out);
        rd(8'h00, m_out, "R4 output readback");

        wr(8'h44, 32'h1200_000F); m_out = m_out & ~32'h1200_000F;
        check("R5 pad_out after clear alias", pad_out, m_out);
        rd(8'h00, m_out, "R5 output readback");

        wr(8'h08, 32'hFFFF_0000); m_dir = 32'hFFFF_0000;
        check("R3 pad_oe after direct write", pad_oe, m_dir);
        check("R3 pad_out unchanged by dir write", pad_out, m_out);
        rd(8'h08, m_dir, "R3 direction readback");

        wr(8'h48, 32'h0000_00F0); m_dir = m_dir | 32'h0000_00F0;
        check("R6 pad_oe after dir set", pad_oe, m_dir);
        wr(8'h4C, 32'h0F00_0000); m_dir = m_dir & ~32'h0F00_0000;
        check("R6 pad_oe after dir clear", pad_oe, m_dir);
        rd(8'h08, m_dir, "R6 direction readback");

        @(negedge clk);
        pad_in = 32'hA5A5_A5A5;
        rd(8'h04, pin_view(), "R7 pad change not yet visible");
        m_pad = 32'hA5A5_A5A5;
        repeat (3) @(negedge clk);
        rd(8'h04, pin_view(), "R7 merged pin view");
        pad_in = 32'h5A5A_5A5A; m_pad = 32'h5A5A_5A5A;
        repeat (3) @(negedge clk);
        rd(8'h04, pin_view(), "R7 merged pin view second pattern");

        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'hFC, 32'h0000_0000);
        check("R8 pad_out after ignored writes", pad_out, m_out);
        check("R8 pad_oe after ignored writes", pad_oe, m_dir);
        rd(8'h00, m_out, "R8 output reg unchanged");
        rd(8'h08, m_dir, "R8 direction reg unchanged");

        rd(8'h40, 32'h0, "R9 read out-set alias");
        rd(8'h44, 32'h0, "R9 read out-clear alias");
        rd(8'h48, 32'h0, "R9 read dir-set alias");
        rd(8'h4C, 32'h0, "R9 read dir-clear alias");
        rd(8'h10, 32'h0, "R9 read unmapped");

        @(negedge clk);
        check("R10 rd_data idle is zero", rd_data, 32'h0);

        wr(8'h44, 32'h0000_0200); m_out = m_out & ~32'h0000_0200;
        wr(8'h40, 32'h0000_0200); m_out = m_out | 32'h0000_0200;
        check("R11 pin still input after value load", pad_oe & 32'h200, 32'h0);
        check("R11 value loaded before enable", pad_out & 32'h200, 32'h200);
        wr(8'h48, 32'h0000_0200); m_dir = m_dir | 32'h0000_0200;
        check("R11 pin enabled", pad_oe & 32'h200, 32'h200);
        check("R11 value held at enable", pad_out & 32'h200, 32'h200);

        wr(8'h08, 32'h0000_0000); m_dir = 32'h0;
        check("R3 all pins input", pad_oe, 32'h0);
        repeat (2) @(negedge clk);
        rd(8'h04, m_pad, "R7 all-input pin view equals pad");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule